// File: doc/BRIEF.md
# CSR Access Instruction Execute Unit

This block carries out the six control-and-status-register access instructions of a small 32-bit core: swap, bit-set and bit-clear, each taking its operand either from a source register value or from a 5-bit unsigned field in the instruction word. Each cycle it receives the instruction word, the value already read for the source register, and the hart's current privilege level. It answers within the same cycle. It returns the previous CSR contents for the destination register and strobes that say whether the CSR was read, whether it is written and with which value, and whether the instruction must be rejected as illegal.

Reads and writes are only requested when the instruction needs them. A swap whose destination is register zero never reads the CSR. A set or clear whose source field is zero never writes it. Read side effects and write side effects therefore happen only when they should.

A small bank of example CSRs sits behind the strobes so that these effects can be seen at the ports: a scratch register, an event accumulator that clears when read, and a read-only tally of accumulator reads. The integer register file, hazard handling and trap entry belong to the surrounding core. This block only flags illegal instructions.

Top module: `csr_exec_unit`

## Requirements
- R1: The CSR address is taken from instruction bits 31:20, the source field from bits 19:15, the destination index from bits 11:7, and the operation from bits 14:12: 001 swap, 010 set, 011 clear, and 101/110/111 the same three with an immediate operand. Codes 000 and 100 are illegal.
- R2: In the immediate forms the 5-bit source field, zero-extended to 32 bits, is the operand in place of `rs1_val`.
- R3: A swap (register or immediate form) with destination index 0 keeps `csr_re` low and causes no read side effect. Every other legal form asserts `csr_re`.
- R4: A legal swap always asserts `csr_we`. A legal set or clear asserts `csr_we` only when its 5-bit source field is nonzero, whatever the value of `rs1_val`.
- R5: `csr_wdata` is the operand for swap, old value OR operand for set, and old value AND NOT operand for clear. It is zero whenever `csr_we` is low.
- R6: `rd_result` is the old CSR value when `csr_re` is high, and zero otherwise. `rd_we` is high for a legal instruction whose destination index is nonzero.
- R7: An instruction that would write a CSR whose address bits 11:10 are 2'b11 is illegal. A pure read of such a CSR is legal.
- R8: With privilege encoded 0 = user, 1 = supervisor, 3 = machine, an access is illegal when `priv` is below the level in address bits 9:8.
- R9: An access to an address outside the bank is illegal. An illegal instruction raises `illegal` and keeps `csr_re`, `csr_we` and `rd_we` low, so no CSR changes.
- R10: The bank holds a scratch register at 0x340 (read-write, reset 0), an event accumulator at 0x5C0 (reset 0, +1 each cycle, cleared by a read, loaded by a write, with the write taking priority), and a 16-bit tally at 0xC03 (read-only, reset 0, +1 for each read of the accumulator).
- R11: While `instr_valid` is low, all strobes and results are zero and no CSR changes apart from the accumulator's own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A CSR instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Value of the source register |
| priv | input | 2 | Current privilege level |
| rd_result | output | 32 | Old CSR value for the destination register |
| rd_we | output | 1 | Destination register write enable |
| csr_re | output | 1 | CSR read performed (side effects fire) |
| csr_we | output | 1 | CSR write performed |
| csr_wdata | output | 32 | Value written to the CSR |
| illegal | output | 1 | Instruction rejected as illegal |

## Verification
Each of the three operations is run in register and immediate form against known scratch contents. This separates the swap, OR and AND-NOT paths, and separates a source-register operand from a zero-extended field. Zero source fields are paired with a nonzero `rs1_val`, which shows that write suppression looks at the field and not at the value. Swaps to the accumulator with destination zero and with a nonzero destination are followed by reads of the tally, which shows whether a read side effect took place. Privilege levels, read-only addresses, unknown addresses and bad operation codes are each tried alone, followed by read-backs that confirm nothing changed.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

   localparam int SRC_W   = 5;
   localparam int ADDR_W  = 12;
   localparam int INSTR_W = 32;

   // Operation kind, equal to the low two bits of the operation field.
   typedef enum logic [1:0] {
      CSR_OP_BAD  = 2'd0,
      CSR_OP_SWAP = 2'd1,
      CSR_OP_SET  = 2'd2,
      CSR_OP_CLR  = 2'd3
   } csr_op_e;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [SRC_W-1:0]  src;
      logic [SRC_W-1:0]  rd;
      csr_op_e           op;
      logic              use_imm;
   } csr_fields_t;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
   import csr_exec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [XLEN-1:0]    rs1_val,
   output csr_fields_t        fields,
   output logic [XLEN-1:0]    operand,
   output logic               op_ok,
   output logic               wr_intent,
   output logic               rd_intent
);

   localparam int PAD_W = XLEN - SRC_W;

   logic [2:0] funct3;

   assign funct3         = instr[14:12];
   assign fields.addr    = instr[31:20];
   assign fields.src     = instr[19:15];
   assign fields.rd      = instr[11:7];
   assign fields.op      = csr_op_e'(funct3[1:0]);
   assign fields.use_imm = funct3[2];

   assign op_ok = (fields.op != CSR_OP_BAD);

   generate
      if (PAD_W > 0) begin : g_pad
         assign operand = fields.use_imm ? {{PAD_W{1'b0}}, fields.src} : rs1_val;
      end else begin : g_nopad
         assign operand = fields.use_imm ? fields.src[XLEN-1:0] : rs1_val;
      end
   endgenerate

   // Swaps always write; set and clear only with a nonzero source field.
   assign wr_intent = (fields.op == CSR_OP_SWAP) || (fields.src != '0);
   // Swaps into x0 skip the read entirely.
   assign rd_intent = !((fields.op == CSR_OP_SWAP) && (fields.rd == '0));

endmodule

// File: rtl/csr_access_check.sv
module csr_access_check
   import csr_exec_pkg::*;
#(
   parameter logic [1:0] RO_CODE = 2'b11
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        priv,
   input  logic              op_ok,
   input  logic              implemented,
   input  logic              wr_intent,
   output logic              reject
);

   logic ro_violation;
   logic priv_violation;

   assign ro_violation   = (addr[11:10] == RO_CODE) && wr_intent;
   assign priv_violation = (priv < addr[9:8]);

   assign reject = !op_ok || !implemented || ro_violation || priv_violation;

endmodule

// File: rtl/csr_bank.sv
module csr_bank
   import csr_exec_pkg::*;
#(
   parameter int                XLEN         = 32,
   parameter int                TALLY_W      = 16,
   parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 12'h340,
   parameter logic [ADDR_W-1:0] EVENT_ADDR   = 12'h5C0,
   parameter logic [ADDR_W-1:0] TALLY_ADDR   = 12'hC03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              re,
   input  logic              we,
   input  logic [XLEN-1:0]   wdata,
   output logic [XLEN-1:0]   rdata,
   output logic              hit
);

   logic              sel_scratch, sel_event, sel_tally;
   logic [XLEN-1:0]   scratch_q;
   logic [XLEN-1:0]   event_q;
   logic [TALLY_W-1:0] tally_q;
   logic [XLEN-1:0]   tally_ext;

   assign sel_scratch = (addr == SCRATCH_ADDR);
   assign sel_event   = (addr == EVENT_ADDR);
   assign sel_tally   = (addr == TALLY_ADDR);
   assign hit         = sel_scratch || sel_event || sel_tally;

   generate
      if (TALLY_W < XLEN) begin : g_tally_pad
         assign tally_ext = {{(XLEN-TALLY_W){1'b0}}, tally_q};
      end else begin : g_tally_full
         assign tally_ext = tally_q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      unique case (1'b1)
         sel_scratch: rdata = scratch_q;
         sel_event:   rdata = event_q;
         sel_tally:   rdata = tally_ext;
         default:     rdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scratch_q <= '0;
      end else if (we && sel_scratch) begin
         scratch_q <= wdata;
      end
   end

   // Write beats clear-on-read, which beats the free count.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         event_q <= '0;
      end else if (we && sel_event) begin
         event_q <= wdata;
      end else if (re && sel_event) begin
         event_q <= '0;
      end else begin
         event_q <= event_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tally_q <= '0;
      end else if (re && sel_event) begin
         tally_q <= tally_q + 1'b1;
      end
   end

endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
   import csr_exec_pkg::*;
#(
   parameter int                XLEN         = 32,
   parameter int                TALLY_W      = 16,
   parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 12'h340,
   parameter logic [ADDR_W-1:0] EVENT_ADDR   = 12'h5C0,
   parameter logic [ADDR_W-1:0] TALLY_ADDR   = 12'hC03
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [31:0]        instr,
   input  logic [XLEN-1:0]    rs1_val,
   input  logic [1:0]         priv,
   output logic [XLEN-1:0]    rd_result,
   output logic               rd_we,
   output logic               csr_re,
   output logic               csr_we,
   output logic [XLEN-1:0]    csr_wdata,
   output logic               illegal
);

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("csr_exec_unit: XLEN must be at least 8");
      end
      if (TALLY_W < 1 || TALLY_W > XLEN) begin : g_bad_tally
         $error("csr_exec_unit: TALLY_W must lie in 1..XLEN");
      end
      if (SCRATCH_ADDR == EVENT_ADDR || SCRATCH_ADDR == TALLY_ADDR ||
          EVENT_ADDR == TALLY_ADDR) begin : g_bad_map
         $error("csr_exec_unit: bank addresses must differ");
      end
   endgenerate

   csr_fields_t      fields;
   logic [XLEN-1:0]  operand;
   logic             op_ok, wr_intent, rd_intent;
   logic             implemented, reject, accept;
   logic [XLEN-1:0]  old_val;
   logic [XLEN-1:0]  new_val;

   csr_decode #(.XLEN(XLEN)) decode_i (
      .instr     (instr),
      .rs1_val   (rs1_val),
      .fields    (fields),
      .operand   (operand),
      .op_ok     (op_ok),
      .wr_intent (wr_intent),
      .rd_intent (rd_intent)
   );

   csr_access_check check_i (
      .addr        (fields.addr),
      .priv        (priv),
      .op_ok       (op_ok),
      .implemented (implemented),
      .wr_intent   (wr_intent),
      .reject      (reject)
   );

   csr_bank #(
      .XLEN         (XLEN),
      .TALLY_W      (TALLY_W),
      .SCRATCH_ADDR (SCRATCH_ADDR),
      .EVENT_ADDR   (EVENT_ADDR),
      .TALLY_ADDR   (TALLY_ADDR)
   ) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (fields.addr),
      .re    (csr_re),
      .we    (csr_we),
      .wdata (csr_wdata),
      .rdata (old_val),
      .hit   (implemented)
   );

   always_comb begin
      unique case (fields.op)
         CSR_OP_SWAP: new_val = operand;
         CSR_OP_SET:  new_val = old_val | operand;
         CSR_OP_CLR:  new_val = old_val & ~operand;
         default:     new_val = '0;
      endcase
   end

   assign accept    = instr_valid && !reject;
   assign illegal   = instr_valid && reject;
   assign csr_re    = accept && rd_intent;
   assign csr_we    = accept && wr_intent;
   assign rd_we     = accept && (fields.rd != '0);
   assign csr_wdata = csr_we ? new_val : '0;
   assign rd_result = csr_re ? old_val : '0;

endmodule

// File: rtl/csr_exec_unit_chk.sv
module csr_exec_unit_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_valid,
   input logic [31:0]     instr,
   input logic [1:0]      priv,
   input logic [XLEN-1:0] rd_result,
   input logic            rd_we,
   input logic            csr_re,
   input logic            csr_we,
   input logic [XLEN-1:0] csr_wdata,
   input logic            illegal
);

   // R9
   quiet_on_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!csr_re && !csr_we && !rd_we));

   // R3
   swap_x0_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr[13:12] == 2'b01 && instr[11:7] == 5'd0) |-> !csr_re);

   // R4
   zero_src_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr[13] && instr[19:15] == 5'd0) |-> !csr_we);

   // R7
   ro_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_we |-> (instr[31:30] != 2'b11));

   // R8
   priv_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we || csr_re) |-> (priv >= instr[29:28]));

   // R11
   idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> (!csr_re && !csr_we && !rd_we && !illegal &&
                        rd_result == '0 && csr_wdata == '0));

   // R5
   wdata_zero_unless_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_we |-> (csr_wdata == '0));

endmodule

bind csr_exec_unit csr_exec_unit_chk #(.XLEN(XLEN)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .priv        (priv),
   .rd_result   (rd_result),
   .rd_we       (rd_we),
   .csr_re      (csr_re),
   .csr_we      (csr_we),
   .csr_wdata   (csr_wdata),
   .illegal     (illegal)
);

// File: tb/csr_exec_unit_tb_top.sv
module csr_exec_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 32;
   localparam logic [11:0] A_SCR = 12'h340;
   localparam logic [11:0] A_EVT = 12'h5C0;
   localparam logic [11:0] A_TAL = 12'hC03;
   localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [XLEN-1:0] rs1_val = '0;
   logic [1:0]      priv = PM;
   logic [XLEN-1:0] rd_result;
   logic            rd_we, csr_re, csr_we, illegal;
   logic [XLEN-1:0] csr_wdata;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csr_exec_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr       (instr),
      .rs1_val     (rs1_val),
      .priv        (priv),
      .rd_result   (rd_result),
      .rd_we       (rd_we),
      .csr_re      (csr_re),
      .csr_we      (csr_we),
      .csr_wdata   (csr_wdata),
      .illegal     (illegal)
   );

   // Behavioural reference state
   logic [31:0] m_scr = '0;
   logic [31:0] m_evt = '0;
   logic [15:0] m_tal = '0;

   function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] s,
                                      input logic [2:0] f, input logic [4:0] d);
      return {a, s, f, d, 7'h73};
   endfunction

   task automatic predict(output logic e_ill, output logic e_re, output logic e_we,
                          output logic e_rdwe, output logic [31:0] e_res,
                          output logic [31:0] e_wd);
      logic [11:0] a;
      logic [4:0]  s, d;
      logic [2:0]  f;
      logic        known, w_int, r_int, bad;
      logic [31:0] opnd, old;
      a = instr[31:20]; s = instr[19:15]; f = instr[14:12]; d = instr[11:7];
      opnd  = f[2] ? {27'd0, s} : rs1_val;
      w_int = (f[1:0] == 2'b01) || (s != 0);
      r_int = !((f[1:0] == 2'b01) && (d == 0));
      known = (a == A_SCR) || (a == A_EVT) || (a == A_TAL);
      old   = (a == A_SCR) ? m_scr : (a == A_EVT) ? m_evt :
              (a == A_TAL) ? {16'd0, m_tal} : 32'd0;
      bad   = (f[1:0] == 2'b00) || !known || (a[11:10] == 2'b11 && w_int) ||
              (priv < a[9:8]);
      e_ill  = instr_valid && bad;
      e_re   = instr_valid && !bad && r_int;
      e_we   = instr_valid && !bad && w_int;
      e_rdwe = instr_valid && !bad && (d != 0);
      e_res  = e_re ? old : 32'd0;
      case (f[1:0])
         2'b01:   e_wd = opnd;
         2'b10:   e_wd = old | opnd;
         2'b11:   e_wd = old & ~opnd;
         default: e_wd = 32'd0;
      endcase
      if (!e_we) e_wd = 32'd0;
   endtask

   logic        p_ill, p_re, p_we, p_rdwe;
   logic [31:0] p_res, p_wd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_scr <= '0; m_evt <= '0; m_tal <= '0;
      end else begin
         predict(p_ill, p_re, p_we, p_rdwe, p_res, p_wd);
         if (p_we && instr[31:20] == A_SCR) m_scr <= p_wd;
         if (p_we && instr[31:20] == A_EVT)      m_evt <= p_wd;
         else if (p_re && instr[31:20] == A_EVT) m_evt <= '0;
         else                                    m_evt <= m_evt + 1;
         if (p_re && instr[31:20] == A_EVT) m_tal <= m_tal + 1;
      end
   end

   task automatic check_val(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // Drive one cycle of stimulus and compare every output with the model.
   task automatic issue(input string req, input logic v, input logic [31:0] ins,
                        input logic [31:0] r1, input logic [1:0] pv);
      logic        e_ill, e_re, e_we, e_rdwe;
      logic [31:0] e_res, e_wd;
      @(negedge clk);
      instr_valid = v; instr = ins; rs1_val = r1; priv = pv;
      #(CLK_PERIOD/4);
      predict(e_ill, e_re, e_we, e_rdwe, e_res, e_wd);
      check_val(req, "illegal",   {31'd0, illegal},   {31'd0, e_ill});
      check_val(req, "csr_re",    {31'd0, csr_re},    {31'd0, e_re});
      check_val(req, "csr_we",    {31'd0, csr_we},    {31'd0, e_we});
      check_val(req, "rd_we",     {31'd0, rd_we},     {31'd0, e_rdwe});
      check_val(req, "rd_result", rd_result,          e_res);
      check_val(req, "csr_wdata", csr_wdata,          e_wd);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10 reset state: scratch and tally read back zero
      issue("R10", 1, mk(A_SCR, 0, 3'b010, 5'd5), 32'h0, PM);
      check_val("R10", "scratch after reset", rd_result, 32'd0);
      issue("R10", 1, mk(A_TAL, 0, 3'b010, 5'd5), 32'h0, PU);
      check_val("R10", "tally after reset", rd_result, 32'd0);

      // R1 R5 R6 register forms on scratch
      issue("R1", 1, mk(A_SCR, 5'd3, 3'b001, 5'd3), 32'hA5A5_0001, PM);
      check_val("R5", "swap wdata", csr_wdata, 32'hA5A5_0001);
      issue("R5", 1, mk(A_SCR, 5'd7, 3'b010, 5'd4), 32'h0000_00F0, PM);
      check_val("R5", "set wdata", csr_wdata, 32'hA5A5_00F1);
      check_val("R6", "set old value", rd_result, 32'hA5A5_0001);
      issue("R5", 1, mk(A_SCR, 5'd8, 3'b011, 5'd4), 32'hA5A5_0001, PM);
      check_val("R5", "clear wdata", csr_wdata, 32'h0000_00F0);

      // R2 immediate forms, upper bits of rs1_val must not leak in
      issue("R2", 1, mk(A_SCR, 5'd31, 3'b101, 5'd2), 32'hFFFF_FFFF, PM);
      check_val("R2", "swap imm wdata", csr_wdata, 32'h0000_001F);
      issue("R2", 1, mk(A_SCR, 5'h10, 3'b110, 5'd2), 32'hFFFF_0000, PM);
      issue("R2", 1, mk(A_SCR, 5'h01, 3'b111, 5'd2), 32'hFFFF_0000, PM);
      check_val("R2", "clear imm wdata", csr_wdata, 32'h0000_001E);

      // R4 zero source fields suppress the write, even with rs1_val nonzero
      issue("R4", 1, mk(A_SCR, 5'd0, 3'b010, 5'd6), 32'hFFFF_FFFF, PM);
      check_val("R4", "set x0 no write", {31'd0, csr_we}, 32'd0);
      issue("R4", 1, mk(A_SCR, 5'd0, 3'b011, 5'd6), 32'hFFFF_FFFF, PM);
      issue("R4", 1, mk(A_SCR, 5'd0, 3'b110, 5'd6), 32'hFFFF_FFFF, PM);
      issue("R4", 1, mk(A_SCR, 5'd0, 3'b010, 5'd6), 32'h0, PM);
      check_val("R4", "scratch unchanged", rd_result, 32'h0000_001E);
      issue("R4", 1, mk(A_SCR, 5'd0, 3'b001, 5'd0), 32'h0, PM);
      check_val("R4", "swap always writes", {31'd0, csr_we}, 32'd1);

      // R3 swap into x0 must not read the accumulator (tally stays)
      issue("R3", 1, mk(A_TAL, 0, 3'b010, 5'd1), 32'h0, PM);
      check_val("R3", "tally baseline", rd_result, 32'd0);
      issue("R3", 1, mk(A_EVT, 5'd2, 3'b001, 5'd0), 32'h0000_1000, PS);
      check_val("R3", "swap x0 csr_re", {31'd0, csr_re}, 32'd0);
      issue("R3", 1, mk(A_TAL, 0, 3'b010, 5'd1), 32'h0, PM);
      check_val("R3", "tally after swap x0", rd_result, 32'd0);
      issue("R3", 1, mk(A_EVT, 5'd9, 3'b101, 5'd0), 32'h0, PS);
      issue("R10", 1, mk(A_EVT, 5'd2, 3'b001, 5'd4), 32'h0000_2000, PS);
      issue("R10", 1, mk(A_TAL, 0, 3'b010, 5'd1), 32'h0, PU);
      check_val("R10", "tally after swap read", rd_result, 32'd1);

      // R10 accumulator: loaded, counts, cleared by read
      issue("R10", 0, 32'h0, 32'h0, PM);
      issue("R10", 1, mk(A_EVT, 0, 3'b010, 5'd4), 32'h0, PS);
      issue("R10", 1, mk(A_EVT, 0, 3'b010, 5'd4), 32'h0, PM);
      check_val("R10", "accumulator after clear", rd_result, 32'd0);

      // R7 read-only tally
      issue("R7", 1, mk(A_TAL, 5'd1, 3'b001, 5'd1), 32'h5, PM);
      check_val("R7", "swap to ro", {31'd0, illegal}, 32'd1);
      issue("R7", 1, mk(A_TAL, 5'd3, 3'b110, 5'd1), 32'h0, PM);
      issue("R7", 1, mk(A_TAL, 5'd0, 3'b110, 5'd1), 32'h0, PM);
      check_val("R7", "ro read legal", {31'd0, illegal}, 32'd0);

      // R8 privilege levels
      issue("R8", 1, mk(A_SCR, 0, 3'b010, 5'd1), 32'h0, PU);
      check_val("R8", "user on machine csr", {31'd0, illegal}, 32'd1);
      issue("R8", 1, mk(A_SCR, 0, 3'b010, 5'd1), 32'h0, PS);
      issue("R8", 1, mk(A_EVT, 0, 3'b010, 5'd1), 32'h0, PU);
      issue("R8", 1, mk(A_EVT, 0, 3'b010, 5'd1), 32'h0, PS);
      check_val("R8", "supervisor on supervisor csr", {31'd0, illegal}, 32'd0);

      // R9 unknown address, and an illegal write leaves scratch alone
      issue("R9", 1, mk(12'h7FF, 5'd1, 3'b001, 5'd1), 32'h1, PM);
      check_val("R9", "unknown addr", {31'd0, illegal}, 32'd1);
      issue("R9", 1, mk(A_SCR, 5'd1, 3'b001, 5'd1), 32'hDEAD_BEEF, PU);
      issue("R9", 1, mk(A_SCR, 0, 3'b010, 5'd1), 32'h0, PM);
      check_val("R9", "scratch kept", rd_result, 32'h0);

      // R1 bad operation codes
      issue("R1", 1, mk(A_SCR, 5'd1, 3'b000, 5'd1), 32'h1, PM);
      check_val("R1", "funct3 000", {31'd0, illegal}, 32'd1);
      issue("R1", 1, mk(A_SCR, 5'd1, 3'b100, 5'd1), 32'h1, PM);
      check_val("R1", "funct3 100", {31'd0, illegal}, 32'd1);

      // R11 invalid cycle carrying a write does nothing
      issue("R11", 0, mk(A_SCR, 5'd1, 3'b001, 5'd1), 32'h1234_5678, PM);
      issue("R11", 1, mk(A_SCR, 0, 3'b010, 5'd1), 32'h0, PM);
      check_val("R11", "scratch after idle write", rd_result, 32'h0);

      repeat (4) issue("R11", 0, 32'h0, 32'h0, PM);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule